// File: doc/BRIEF.md
# DMA Request and Access Port for an Endpoint Buffer

This block sits between a system DMA engine and the endpoint packet buffers of a USB device controller. Software picks one endpoint through a small control register, and the block then raises a request line whenever that buffer can take part in a transfer. A transfer can take place when the buffer has room for a transmit endpoint, or holds data for a receive endpoint. Each DMA data access is recognised in one of three strobe formats. The block turns it into a single push or pop on a plain buffer port, 8 or 16 bits wide.

The request can behave in two ways. In cycle-steal mode it is raised once per transfer and then withdrawn. In burst mode it is held across the whole buffer and drops on the access that empties or fills it. A transmit packet shorter than the buffer is closed in one of two ways: by a terminal-count pin sampled with the final write, or by software setting a commit bit. Either way the buffer side receives a commit pulse carrying the packet's byte count. A software flag marks a 16-bit final write as carrying only its low byte.

Top module: `dmaport_ctrl`

## Requirements
- R1: The control register (reg_addr 0) holds the endpoint in bits [2:0], the enable in bit 3, the burst mode in bit 4, the access format in bits [6:5] and the 16-bit width in bit 7, and takes effect from the clock edge that writes it. The command register (reg_addr 1) holds the commit bit in bit 0 and the odd-tail flag in bit 1. After reset every field is 0, dma_req is low, and no push, pop or commit occurs.
- R2: Only endpoints 1 to 6 can be served. With endpoint 0 or 7 selected, dma_req stays low and every access is ignored.
- R3: dma_req is high only while the enable is set and the selected endpoint's ep_ready is high, and no mode-specific hold-off (R9, R10) is active.
- R4: Format 00 accepts an access when dma_ack is high together with dma_wr (write) or dma_rd (read). dma_cs and dma_addr are ignored.
- R5: Format 01 accepts an access on dma_ack alone, with the direction taken from ep_dir of the selected endpoint. dma_rd and dma_wr are ignored. In burst mode format 01 accepts nothing.
- R6: Format 10 accepts an access when dma_cs is high, dma_addr equals 6, and dma_wr or dma_rd is high. dma_ack is ignored. Format 11 accepts nothing.
- R7: A write is accepted only when the selected endpoint has ep_dir 1 (transmit), and a read only when it has ep_dir 0. Accesses are ignored while the selected ep_ready is low. An accepted write pulses fifo_push in the same cycle, and an accepted read pulses fifo_pop in the same cycle.
- R8: With the width bit 0, a push carries fifo_wbytes 1 and only the low byte of dma_wdata (upper byte zero), and dma_rdata returns the low byte of fifo_rdata zero-extended. With the width bit 1, both bytes pass through and fifo_wbytes is 2.
- R9: In cycle-steal mode, dma_req falls in the cycle of each accepted access, stays low in the following cycle, and returns after that if the buffer is still ready.
- R10: In burst mode, dma_req stays high across accepted accesses. It falls in the cycle of an access made while the selected ep_last is high. It then stays low until ep_ready has been seen low and has risen again.
- R11: An accepted write with dma_tc high produces a one-cycle fifo_commit on the next cycle. Its fifo_commit_bytes is the sum of the fifo_wbytes of all accepted writes since the previous commit, this write included, and the count then restarts at 0.
- R12: Writing 1 to the commit bit produces a one-cycle fifo_commit on the next cycle with the accumulated count. When it coincides with a terminal-count write, exactly one commit is produced, and its count includes that write.
- R13: While the odd-tail flag is set, a 16-bit write with dma_tc high carries fifo_wbytes 1 and adds only 1 to the committed count. Every commit clears the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 control, 1 command |
| reg_wdata | input | 8 | Register write data |
| dma_req | output | 1 | DMA request |
| dma_ack | input | 1 | DMA acknowledge |
| dma_rd | input | 1 | Read strobe |
| dma_wr | input | 1 | Write strobe |
| dma_cs | input | 1 | Chip select |
| dma_addr | input | 4 | Register address for chip-select accesses |
| dma_tc | input | 1 | Terminal count, sampled with a write |
| dma_wdata | input | 16 | Write data from the DMA side |
| dma_rdata | output | 16 | Read data to the DMA side |
| ep_ready | input | 8 | Per-endpoint buffer ready (space or data) |
| ep_last | input | 8 | Per-endpoint: next access empties or fills the buffer |
| ep_dir | input | 8 | Per-endpoint direction, 1 transmit |
| fifo_ep | output | 3 | Endpoint served by the buffer port |
| fifo_push | output | 1 | Write one unit into the buffer |
| fifo_pop | output | 1 | Read one unit from the buffer |
| fifo_wbytes | output | 2 | Valid bytes in the pushed unit |
| fifo_wdata | output | 16 | Data pushed into the buffer |
| fifo_rdata | input | 16 | Data at the buffer head |
| fifo_commit | output | 1 | Close the transmit packet |
| fifo_commit_bytes | output | 11 | Byte count of the closed packet |

## Verification
Two commit sources can land on the same clock edge: a write carrying the terminal count, and a software write of the commit bit. The bench drives both in one cycle, on a 16-bit write, after clearing the running count. It then checks three things: a single commit pulse appears on the next cycle, its count is exactly the two bytes of that write, and no second pulse follows. A later software commit with a count of zero shows that the counter restarted only once. A related collision is the burst-ending access, in which the request must fall in the same cycle as the push it accompanies. The bench samples both in that one cycle.

// File: rtl/dmaport_pkg.sv
package dmaport_pkg;
    localparam int EP_W   = 3;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        FMT_ACK_STROBE = 2'b00,
        FMT_ACK_ONLY   = 2'b01,
        FMT_CS_ADDR    = 2'b10,
        FMT_NONE       = 2'b11
    } fmt_e;

    // control register image, MSB first: width, format, burst, enable, endpoint
    typedef struct packed {
        logic            wide;
        fmt_e            fmt;
        logic            burst;
        logic            en;
        logic [EP_W-1:0] ep;
    } ctrl_t;
endpackage

// File: rtl/dmaport_decode.sv
module dmaport_decode
    import dmaport_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int DATA_ADDR = 6
) (
    input  ctrl_t                  ctrl,
    input  logic                   rdy,
    input  logic                   dir_tx,
    input  logic                   odd_tail,
    input  logic                   ack,
    input  logic                   rd,
    input  logic                   wr,
    input  logic                   cs,
    input  logic [ADDR_W-1:0]      addr,
    input  logic                   tc,
    input  logic [2*BYTE_W-1:0]    wdata_in,
    input  logic [2*BYTE_W-1:0]    rdata_in,
    output logic                   acc_wr,
    output logic                   acc_rd,
    output logic [1:0]             wbytes,
    output logic [2*BYTE_W-1:0]    wdata_out,
    output logic [2*BYTE_W-1:0]    rdata_out
);
    localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(DATA_ADDR);

    logic q_wr, q_rd;

    always_comb begin
        q_wr = 1'b0;
        q_rd = 1'b0;
        unique case (ctrl.fmt)
            FMT_ACK_STROBE: begin
                q_wr = ack & wr;
                q_rd = ack & rd;
            end
            FMT_ACK_ONLY: begin
                q_wr = ack & dir_tx & ~ctrl.burst;
                q_rd = ack & ~dir_tx & ~ctrl.burst;
            end
            FMT_CS_ADDR: begin
                q_wr = cs & (addr == HIT_ADDR) & wr;
                q_rd = cs & (addr == HIT_ADDR) & rd;
            end
            default: ;
        endcase
        acc_wr = rdy & dir_tx & q_wr;
        acc_rd = rdy & ~dir_tx & q_rd;

        if (ctrl.wide) begin
            wbytes    = (odd_tail && tc) ? 2'd1 : 2'd2;
            wdata_out = wdata_in;
            rdata_out = rdata_in;
        end else begin
            wbytes    = 2'd1;
            wdata_out = {{BYTE_W{1'b0}}, wdata_in[BYTE_W-1:0]};
            rdata_out = {{BYTE_W{1'b0}}, rdata_in[BYTE_W-1:0]};
        end
    end
endmodule

// File: rtl/dmaport_req.sv
module dmaport_req (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic burst,
    input  logic rdy,
    input  logic last,
    input  logic acc,
    output logic req
);
    typedef struct packed {
        logic gap;   // cycle-steal rest cycle after a transfer
        logic hold;  // burst finished, waiting for ready to fall
    } st_t;

    st_t  st_d, st_q;
    logic kill;

    always_comb begin
        kill      = acc & (~burst | last);
        req       = en & rdy & ~kill & ~st_q.gap & ~st_q.hold;
        st_d.gap  = acc & ~burst;
        st_d.hold = burst & ((acc & last) | (st_q.hold & rdy));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R9: a cycle-steal transfer leaves one cycle without request
    p_cs_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !burst) |=> !req);
    // R10: a burst-ending transfer keeps the request down afterwards
    p_burst_end_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && burst && last) |=> !req);
    // R10: the hold-off releases once ready has been seen low
    p_hold_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.hold && !rdy) |=> !st_q.hold);
endmodule

// File: rtl/dmaport_commit.sv
module dmaport_commit #(
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_wr,
    input  logic [1:0]       wbytes,
    input  logic             trig,
    output logic             commit,
    output logic [CNT_W-1:0] commit_bytes
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             pulse;
        logic [CNT_W-1:0] bytes;
    } st_t;

    st_t              st_d, st_q;
    logic [CNT_W-1:0] total;

    always_comb begin
        total      = st_q.cnt + (acc_wr ? CNT_W'(wbytes) : '0);
        st_d       = st_q;
        st_d.pulse = trig;
        if (trig) begin
            st_d.bytes = total;
            st_d.cnt   = '0;
        end else begin
            st_d.cnt   = total;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign commit       = st_q.pulse;
    assign commit_bytes = st_q.bytes;

    // R11: the counter restarts after every commit
    p_count_restart_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && !acc_wr) |=> (st_q.cnt == '0));
endmodule

// File: rtl/dmaport_ctrl.sv
module dmaport_ctrl
    import dmaport_pkg::*;
#(
    parameter int EP_LO     = 1,
    parameter int EP_HI     = 6,
    parameter int ADDR_W    = 4,
    parameter int DATA_ADDR = 6,
    parameter int CNT_W     = 11
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_we,
    input  logic                reg_addr,
    input  logic [7:0]          reg_wdata,
    output logic                dma_req,
    input  logic                dma_ack,
    input  logic                dma_rd,
    input  logic                dma_wr,
    input  logic                dma_cs,
    input  logic [ADDR_W-1:0]   dma_addr,
    input  logic                dma_tc,
    input  logic [15:0]         dma_wdata,
    output logic [15:0]         dma_rdata,
    input  logic [7:0]          ep_ready,
    input  logic [7:0]          ep_last,
    input  logic [7:0]          ep_dir,
    output logic [2:0]          fifo_ep,
    output logic                fifo_push,
    output logic                fifo_pop,
    output logic [1:0]          fifo_wbytes,
    output logic [15:0]         fifo_wdata,
    input  logic [15:0]         fifo_rdata,
    output logic                fifo_commit,
    output logic [CNT_W-1:0]    fifo_commit_bytes
);
    localparam logic [EP_W-1:0] SEL_LO    = EP_W'(EP_LO);
    localparam logic [EP_W-1:0] SEL_HI    = EP_W'(EP_HI);
    localparam logic            REG_CTRL  = 1'b0;
    localparam logic            REG_CMD   = 1'b1;
    localparam int              BIT_VALID = 0;
    localparam int              BIT_ODD   = 1;

    typedef struct packed {
        ctrl_t ctrl;
        logic  odd;
    } st_t;

    st_t  st_d, st_q;
    logic sel_ok, rdy, last, dir_tx, valid_set, trig;
    logic acc_wr, acc_rd;

    always_comb begin
        sel_ok    = (st_q.ctrl.ep >= SEL_LO) && (st_q.ctrl.ep <= SEL_HI);
        rdy       = sel_ok & ep_ready[st_q.ctrl.ep];
        last      = ep_last[st_q.ctrl.ep];
        dir_tx    = ep_dir[st_q.ctrl.ep];
        valid_set = reg_we & (reg_addr == REG_CMD) & reg_wdata[BIT_VALID];
        trig      = (acc_wr & dma_tc) | valid_set;

        st_d = st_q;
        if (reg_we && reg_addr == REG_CTRL) st_d.ctrl = ctrl_t'(reg_wdata);
        if (reg_we && reg_addr == REG_CMD)  st_d.odd  = reg_wdata[BIT_ODD];
        if (trig)                           st_d.odd  = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    dmaport_decode #(.ADDR_W(ADDR_W), .DATA_ADDR(DATA_ADDR)) u_decode (
        .ctrl      (st_q.ctrl),
        .rdy       (rdy),
        .dir_tx    (dir_tx),
        .odd_tail  (st_q.odd),
        .ack       (dma_ack),
        .rd        (dma_rd),
        .wr        (dma_wr),
        .cs        (dma_cs),
        .addr      (dma_addr),
        .tc        (dma_tc),
        .wdata_in  (dma_wdata),
        .rdata_in  (fifo_rdata),
        .acc_wr    (acc_wr),
        .acc_rd    (acc_rd),
        .wbytes    (fifo_wbytes),
        .wdata_out (fifo_wdata),
        .rdata_out (dma_rdata)
    );

    dmaport_req u_req (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (st_q.ctrl.en),
        .burst (st_q.ctrl.burst),
        .rdy   (rdy),
        .last  (last),
        .acc   (acc_wr | acc_rd),
        .req   (dma_req)
    );

    dmaport_commit #(.CNT_W(CNT_W)) u_commit (
        .clk          (clk),
        .rst_n        (rst_n),
        .acc_wr       (acc_wr),
        .wbytes       (fifo_wbytes),
        .trig         (trig),
        .commit       (fifo_commit),
        .commit_bytes (fifo_commit_bytes)
    );

    assign fifo_ep   = st_q.ctrl.ep;
    assign fifo_push = acc_wr;
    assign fifo_pop  = acc_rd;

    // R7: the buffer port never moves data for an unready buffer
    p_move_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_push || fifo_pop) |-> ep_ready[fifo_ep]);
    // R7: one direction per cycle
    p_one_dir_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(fifo_push && fifo_pop));
    // R2: no request outside the DMA-capable endpoints
    p_sel_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req |-> (fifo_ep >= SEL_LO && fifo_ep <= SEL_HI));
    // R11: a terminal-count write is followed by a commit
    p_tc_commit_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_push && dma_tc) |=> fifo_commit);
    // R8: narrow pushes carry one byte
    p_narrow_bytes_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_push && !st_q.ctrl.wide) |-> (fifo_wbytes == 2'd1));
endmodule

// File: tb/sim_dmaport_ctrl.sv
`timescale 1ns/1ps
module sim_dmaport_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0, reg_addr = 1'b0;
    logic [7:0]  reg_wdata = '0;
    logic        dma_req, dma_ack = 0, dma_rd = 0, dma_wr = 0, dma_cs = 0, dma_tc = 0;
    logic [3:0]  dma_addr = '0;
    logic [15:0] dma_wdata = '0, dma_rdata, fifo_wdata, fifo_rdata = '0;
    logic [7:0]  ep_ready = '0, ep_last = '0, ep_dir = '0;
    logic [2:0]  fifo_ep;
    logic        fifo_push, fifo_pop, fifo_commit;
    logic [1:0]  fifo_wbytes;
    logic [10:0] fifo_commit_bytes;

    int n_chk = 0, n_fail = 0;
    logic        s_req, s_push, s_pop;
    logic [1:0]  s_wb;
    logic [15:0] s_wd, s_rd;

    always #10 clk = ~clk;

    dmaport_ctrl u0 (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic idle();
        @(negedge clk); #1;
    endtask

    task automatic wr_reg(input logic a, input logic [7:0] d);
        @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_we = 0; #1;
    endtask

    task automatic cfg(input logic [2:0] ep, input logic en, input logic burst,
                       input logic [1:0] fmt, input logic wide);
        wr_reg(1'b0, {wide, fmt, burst, en, ep});
    endtask

    // one access cycle; samples combinational outputs inside it
    task automatic acc(input logic ack, input logic rd, input logic wr, input logic cs,
                       input logic [3:0] addr, input logic tc, input logic [15:0] wd,
                       input logic vset);
        @(negedge clk);
        dma_ack = ack; dma_rd = rd; dma_wr = wr; dma_cs = cs; dma_addr = addr;
        dma_tc = tc; dma_wdata = wd;
        if (vset) begin reg_we = 1; reg_addr = 1; reg_wdata = 8'h01; end
        #1;
        s_req = dma_req; s_push = fifo_push; s_pop = fifo_pop;
        s_wb = fifo_wbytes; s_wd = fifo_wdata; s_rd = dma_rdata;
        @(negedge clk);
        dma_ack = 0; dma_rd = 0; dma_wr = 0; dma_cs = 0; dma_tc = 0; reg_we = 0;
        #1;
    endtask

    task automatic t_reset();
        chk("R1 reset req", dma_req, 0);
        chk("R1 reset push", fifo_push, 0);
        chk("R1 reset commit", fifo_commit, 0);
        ep_ready = 8'hFF; ep_dir = 8'hFF; idle();
        chk("R1 disabled after reset", dma_req, 0);
    endtask

    task automatic t_request();
        cfg(3'd2, 1, 0, 2'b00, 0);
        chk("R1 ctrl write takes effect / R3 req", dma_req, 1);
        chk("R1 endpoint on port", fifo_ep, 2);
        cfg(3'd2, 0, 0, 2'b00, 0);
        chk("R3 enable clear", dma_req, 0);
        cfg(3'd2, 1, 0, 2'b00, 0);
        @(negedge clk); ep_ready[2] = 0; #1;
        chk("R3 not ready", dma_req, 0);
        @(negedge clk); ep_ready[2] = 1; #1;
    endtask

    task automatic t_range();
        cfg(3'd0, 1, 0, 2'b00, 0);
        chk("R2 ep0 req", dma_req, 0);
        acc(1, 0, 1, 0, 0, 0, 16'h11, 0);
        chk("R2 ep0 push", s_push, 0);
        cfg(3'd7, 1, 0, 2'b00, 0);
        chk("R2 ep7 req", dma_req, 0);
        acc(1, 0, 1, 0, 0, 0, 16'h11, 0);
        chk("R2 ep7 push", s_push, 0);
    endtask

    task automatic t_formats();
        cfg(3'd3, 1, 0, 2'b00, 0);
        acc(1, 0, 1, 0, 0, 0, 16'h5, 0);   chk("R4 ack+wr", s_push, 1);
        acc(0, 0, 1, 1, 6, 0, 16'h5, 0);   chk("R4 cs/addr ignored", s_push, 0);
        acc(1, 0, 0, 0, 0, 0, 16'h5, 0);   chk("R4 ack alone", s_push, 0);
        cfg(3'd3, 1, 0, 2'b01, 0);
        acc(1, 0, 0, 0, 0, 0, 16'h5, 0);   chk("R5 ack alone push", s_push, 1);
        @(negedge clk); ep_dir[3] = 0; #1;
        acc(1, 0, 1, 0, 0, 0, 16'h5, 0);   chk("R5 ack alone pops rx", s_pop, 1);
        chk("R5 strobe ignored no push", s_push, 0);
        @(negedge clk); ep_dir[3] = 1; #1;
        cfg(3'd3, 1, 1, 2'b01, 0);
        acc(1, 0, 1, 0, 0, 0, 16'h5, 0);   chk("R5 burst format01 none", s_push, 0);
        cfg(3'd3, 1, 0, 2'b10, 0);
        acc(0, 0, 1, 1, 6, 0, 16'h5, 0);   chk("R6 cs+addr6+wr", s_push, 1);
        acc(0, 0, 1, 1, 5, 0, 16'h5, 0);   chk("R6 wrong addr", s_push, 0);
        acc(1, 0, 1, 0, 6, 0, 16'h5, 0);   chk("R6 ack ignored", s_push, 0);
        cfg(3'd3, 1, 0, 2'b11, 0);
        acc(1, 1, 1, 1, 6, 0, 16'h5, 0);   chk("R6 format11 none", s_push | s_pop, 0);
    endtask

    task automatic t_dir_width();
        cfg(3'd3, 1, 0, 2'b00, 0);
        acc(1, 1, 0, 0, 0, 0, 16'h5, 0);   chk("R7 read on tx ignored", s_pop, 0);
        @(negedge clk); ep_ready[3] = 0; #1;
        acc(1, 0, 1, 0, 0, 0, 16'h5, 0);   chk("R7 unready ignored", s_push, 0);
        @(negedge clk); ep_ready[3] = 1; #1;
        acc(1, 0, 1, 0, 0, 0, 16'hABCD, 0);
        chk("R8 narrow data", s_wd, 16'h00CD);
        chk("R8 narrow bytes", s_wb, 1);
        cfg(3'd3, 1, 0, 2'b00, 1);
        acc(1, 0, 1, 0, 0, 0, 16'hABCD, 0);
        chk("R8 wide data", s_wd, 16'hABCD);
        chk("R8 wide bytes", s_wb, 2);
        cfg(3'd4, 1, 0, 2'b00, 0);
        @(negedge clk); ep_dir[4] = 0; fifo_rdata = 16'h1234; #1;
        acc(1, 1, 0, 0, 0, 0, 16'h0, 0);
        chk("R7 rx read pops", s_pop, 1);
        chk("R8 narrow read data", s_rd, 16'h0034);
    endtask

    task automatic t_cycle_steal();
        cfg(3'd2, 1, 0, 2'b00, 0);
        chk("R9 req before", dma_req, 1);
        acc(1, 0, 1, 0, 0, 0, 16'h1, 0);
        chk("R9 req low in access", s_req, 0);
        chk("R9 req low next cycle", dma_req, 0);
        idle();
        chk("R9 req returns", dma_req, 1);
    endtask

    task automatic t_burst();
        cfg(3'd2, 1, 1, 2'b00, 0);
        acc(1, 0, 1, 0, 0, 0, 16'h1, 0);
        chk("R10 held in access", s_req, 1);
        chk("R10 held after", dma_req, 1);
        @(negedge clk); ep_last[2] = 1; #1;
        acc(1, 0, 1, 0, 0, 0, 16'h1, 0);
        chk("R10 drops with last", s_req, 0);
        chk("R10 last push", s_push, 1);
        @(negedge clk); ep_last[2] = 0; #1;
        chk("R10 stays low while ready", dma_req, 0);
        @(negedge clk); ep_ready[2] = 0;
        @(negedge clk); ep_ready[2] = 1; #1;
        chk("R10 returns after ready cycle", dma_req, 1);
    endtask

    task automatic t_commit();
        cfg(3'd2, 1, 0, 2'b00, 1);
        wr_reg(1'b1, 8'h01);                 // flush counter
        idle();
        acc(1, 0, 1, 0, 0, 0, 16'h1, 0);
        acc(1, 0, 1, 0, 0, 0, 16'h2, 0);
        chk("R11 no commit before tc", fifo_commit, 0);
        acc(1, 0, 1, 0, 0, 1, 16'h3, 0);
        chk("R11 tc commit", fifo_commit, 1);
        chk("R11 tc bytes", fifo_commit_bytes, 6);
        cfg(3'd2, 1, 0, 2'b00, 0);
        acc(1, 0, 1, 0, 0, 0, 16'h4, 0);
        wr_reg(1'b1, 8'h01);
        chk("R12 valid commit", fifo_commit, 1);
        chk("R12 valid bytes", fifo_commit_bytes, 1);
        cfg(3'd2, 1, 0, 2'b00, 1);
        acc(1, 0, 1, 0, 0, 1, 16'h5, 1);
        chk("R12 coincident commit", fifo_commit, 1);
        chk("R12 coincident bytes", fifo_commit_bytes, 2);
        idle();
        chk("R12 single pulse", fifo_commit, 0);
        wr_reg(1'b1, 8'h01);
        chk("R12 count restarted", fifo_commit_bytes, 0);
        wr_reg(1'b1, 8'h02);                 // odd tail
        acc(1, 0, 1, 0, 0, 0, 16'h6, 0);
        chk("R13 full word before tail", s_wb, 2);
        acc(1, 0, 1, 0, 0, 1, 16'h7, 0);
        chk("R13 tail one byte", s_wb, 1);
        chk("R13 tail bytes", fifo_commit_bytes, 3);
        acc(1, 0, 1, 0, 0, 1, 16'h8, 0);
        chk("R13 flag cleared", fifo_commit_bytes, 2);
    endtask

    initial begin
        #(20 * 20000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_request();
        t_range();
        t_formats();
        t_dir_width();
        t_cycle_steal();
        t_burst();
        t_commit();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule